// File: doc/BRIEF.md
# Periodic Interval Timer

This block raises a level interrupt at a fixed, programmable interval. A prescaler divides the system clock down to a one-millisecond tick. A period counter counts those ticks. Software writes a reload value R, and each period then lasts R+1 milliseconds, which gives a rate of 1000/(R+1) Hz. The timer runs without stopping: when a period ends it raises the interrupt and starts the next period at once.

Software uses two register slots, chosen with `regSel`. Slot 0 holds the reload value and can be read and written. Slot 1 is the count slot. Reading it returns zero and acknowledges the interrupt. Writing it does nothing. Writing the reload slot also clears any pending interrupt and restarts the period from zero using the new value.

Top module: `ivl_timer`

## Requirements
- R1: After reset, `irqOut` is 0 and a read of the reload slot (`regSel`=0) returns 0.
- R2: After a write of value R to the reload slot, taken at clock edge E, `irqOut` first goes high at edge E + (R+1)·TICK_DIV. This holds for R = 0 through the largest value R can take.
- R3: When a period ends while `irqOut` is already high, `irqOut` stays high and no second event is recorded.
- R4: A read of the count slot (`regSel`=1) returns zero on `rdData`, and `irqOut` is 0 after that clock edge.
- R5: A write to the reload slot makes `irqOut` 0 after that edge. The period then restarts from zero with the new value.
- R6: A read of the reload slot returns the value most recently written to it.
- R7: A write to the count slot changes neither the reload value nor when the next interrupt occurs.
- R8: An acknowledge does not move the period boundaries. After an acknowledge, the next rise of `irqOut` lands on the next multiple of (R+1)·TICK_DIV counted from the reload write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register slot: 0 = reload, 1 = count/acknowledge |
| wrEn | input | 1 | Write strobe for the selected slot |
| rdEn | input | 1 | Read strobe for the selected slot |
| wrData | input | RELOAD_W | Write data |
| rdData | output | RELOAD_W | Read data (combinational from `regSel`) |
| irqOut | output | 1 | Level interrupt, high from period end until acknowledged |

## Verification
The hardest cases to reach are a period that ends while the interrupt is still pending, and an acknowledge that falls in the middle of a period. Both depend only on how long software waits, so the stimulus sets them up by timing alone. It leaves the interrupt unacknowledged across a whole extra period and then confirms that the line stayed high. It acknowledges shortly after a rise and predicts the next rise from the original write edge rather than from the acknowledge. A count-slot write placed in the middle of the longest period checks that such a write does not disturb the schedule.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

  localparam logic SEL_RELOAD = 1'b0;
  localparam logic SEL_COUNT  = 1'b1;

  typedef struct packed {
    logic restart;  // reload written: clear irq, restart period
    logic ack;      // count slot read: clear irq
  } tmrStrobes_t;

endpackage

// File: rtl/ivl_timer_ctrl.sv
module ivl_timer_ctrl
  import ivl_timer_pkg::*;
#(
  parameter int RELOAD_W = 8
) (
  input  logic                regSel,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [RELOAD_W-1:0] reloadVal,
  output tmrStrobes_t         strobes,
  output logic [RELOAD_W-1:0] rdData
);

  always_comb begin
    strobes.restart = wrEn && (regSel == SEL_RELOAD);
    strobes.ack     = rdEn && (regSel == SEL_COUNT);
  end

  // The count slot always reads as zero.
  assign rdData = (regSel == SEL_RELOAD) ? reloadVal : '0;

endmodule

// File: rtl/ivl_timer_dp.sv
module ivl_timer_dp
  import ivl_timer_pkg::*;
#(
  parameter int RELOAD_W = 8,
  parameter int TICK_DIV = 100000
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmrStrobes_t         strobes,
  input  logic [RELOAD_W-1:0] wrData,
  output logic [RELOAD_W-1:0] reloadVal,
  output logic                irq
);

  localparam int CNT_W = RELOAD_W + 1;
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic             tick;
  logic [CNT_W-1:0] periodCnt;
  logic             periodEnd;
  logic             clearIrq;

  // Millisecond prescaler; the variant depends on the divide ratio
  generate
    if (TICK_DIV == 1) begin : g_noPre
      assign tick = 1'b1;
    end else begin : g_pre
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || strobes.restart)  preCnt <= '0;
        else if (preCnt == PRE_LAST)   preCnt <= '0;
        else                           preCnt <= preCnt + 1'b1;
      end
      assign tick = (preCnt == PRE_LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)                  reloadVal <= '0;
    else if (strobes.restart)   reloadVal <= wrData;
  end

  // Period counter holds the ticks left in the current period (1..R+1)
  always_ff @(posedge clk) begin
    if (!rstN)                 periodCnt <= CNT_W'(1);
    else if (strobes.restart)  periodCnt <= {1'b0, wrData} + 1'b1;
    else if (tick) begin
      if (periodCnt == CNT_W'(1)) periodCnt <= {1'b0, reloadVal} + 1'b1;
      else                        periodCnt <= periodCnt - 1'b1;
    end
  end

  assign periodEnd = tick && (periodCnt == CNT_W'(1));
  assign clearIrq  = strobes.restart || strobes.ack;

  // Clearing wins over a coincident period end
  always_ff @(posedge clk) begin
    if (!rstN || clearIrq)  irq <= 1'b0;
    else if (periodEnd)     irq <= 1'b1;
  end

  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    periodCnt != '0);                                                   // R2
  AST_IRQ_ON_END: assert property (@(posedge clk) disable iff (!rstN)
    (periodEnd && !clearIrq) |=> irq);                                  // R2
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clearIrq) |=> irq);                                        // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ack |=> !irq);                                              // R4
  AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> (!irq && reloadVal == $past(wrData)));          // R5

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int RELOAD_W = 8,
  parameter int TICK_DIV = 100000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regSel,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [RELOAD_W-1:0] wrData,
  output logic [RELOAD_W-1:0] rdData,
  output logic                irqOut
);

  tmrStrobes_t         strobes;
  logic [RELOAD_W-1:0] reloadVal;

  ivl_timer_ctrl #(.RELOAD_W(RELOAD_W)) u_ctrl (
    .regSel    (regSel),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .reloadVal (reloadVal),
    .strobes   (strobes),
    .rdData    (rdData)
  );

  ivl_timer_dp #(.RELOAD_W(RELOAD_W), .TICK_DIV(TICK_DIV)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (wrData),
    .reloadVal (reloadVal),
    .irq       (irqOut)
  );

endmodule

// File: tb/ivl_timer_test.sv
module ivl_timer_test;

  localparam int RW  = 4;
  localparam int DIV = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regSel = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [RW-1:0] wrData = '0;
  logic [RW-1:0] rdData;
  logic          irqOut;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int expQ[$];
  logic prevIrq = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ivl_timer #(.RELOAD_W(RW), .TICK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: every rising edge of irqOut must match the oldest expectation
  always @(negedge clk) begin
    if (rstN && irqOut && !prevIrq) begin
      if (expQ.size() == 0) check("R3 unexpected irq rise", cyc, -1);
      else                  check("R2/R8 irq rise cycle", cyc, expQ.pop_front());
    end
    prevIrq <= irqOut;
  end

  // Driver tasks, called at a negative edge
  task automatic wr(input logic sel, input int data, output int edgeCyc);
    regSel = sel; wrData = RW'(data); wrEn = 1'b1;
    @(posedge clk); #1 edgeCyc = cyc;
    wrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic sel, output int data);
    regSel = sel; rdEn = 1'b1;
    #1 data = int'(rdData);
    @(posedge clk); #1 rdEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int c0, c1, c2, d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 irq after reset", int'(irqOut), 0);
    rd(1'b0, d);
    check("R1 reload after reset", d, 0);

    // R2: period of 4 ticks, then R3 hold across a further end
    wr(1'b0, 3, c0);
    expQ.push_back(c0 + 4*DIV);
    waitCyc(4*DIV + 2);
    check("R2 irq high after period", int'(irqOut), 1);
    rd(1'b0, d);
    check("R6 reload readback", d, 3);
    // R4: acknowledge
    rd(1'b1, d);
    check("R4 count read is zero", d, 0);
    check("R4 irq cleared by read", int'(irqOut), 0);
    // R8: next rise on the original schedule
    expQ.push_back(c0 + 8*DIV);
    waitCyc(4*DIV);
    check("R8 irq high at next boundary", int'(irqOut), 1);
    // R3: one more period end passes while still high
    waitCyc(4*DIV);
    check("R3 irq held across period end", int'(irqOut), 1);

    // R5: reload write clears and restarts, shortest period
    wr(1'b0, 0, c1);
    check("R5 irq cleared by reload write", int'(irqOut), 0);
    expQ.push_back(c1 + DIV);
    waitCyc(DIV + 3);
    check("R2 irq high after minimum period", int'(irqOut), 1);

    // R2 at maximum reload, R7 count write mid-period
    wr(1'b0, 15, c2);
    check("R5 irq cleared by second write", int'(irqOut), 0);
    expQ.push_back(c2 + 16*DIV);
    waitCyc(50);
    wr(1'b1, 5, d);
    rd(1'b0, d);
    check("R7 reload unchanged by count write", d, 15);
    check("R7 irq still low mid-period", int'(irqOut), 0);
    waitCyc(16*DIV);
    check("R7 irq high at unchanged boundary", int'(irqOut), 1);
    rd(1'b1, d);
    check("R4 count read zero again", d, 0);
    check("R4 irq low after ack", int'(irqOut), 0);
    check("R2 all expected rises seen", expQ.size(), 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule